// File: doc/BRIEF.md
# Outbound Address Translator with Indexed Region Window

This block maps addresses issued on the processor side to addresses on the downstream bus. It holds a small set of outbound translation regions. Each region has a 64-bit base, a 32-bit inclusive upper limit on the low word, a 64-bit target and a transaction-type code. Software never addresses a region directly. It first writes a window-select register that picks a direction and a region index. It then writes a shared group of registers, and those writes land in the region just selected.

On each cycle with `req_valid` high, the block compares `req_addr` against all enabled outbound regions. One cycle later it presents the translated address and the winning region's type code. When no region matches, it presents the address unchanged and raises a miss flag. Inbound regions can be written and read back through the same window. They never take part in a lookup.

Top module: `obaddr_xlate`

## Requirements
- R1: After reset, `out_valid` is 0, every region is disabled, all stored fields and the window select read back as 0, and every lookup misses.
- R2: The window select sits at offset 0x900. Bit 31 picks the direction (0 outbound, 1 inbound) and bits [IDX_W-1:0] pick the region (IDX_W = 2 by default). Reading it returns those bits, and every other bit reads 0.
- R3: The selected region's fields are reached at these offsets. The type code is in bits [2:0] of 0x904, with memory 0, I/O 2, config type 0 = 4 and config type 1 = 5. The enable is bit 31 of 0x908. The remaining fields are low base 0x90C, high base 0x910, low limit 0x914, low target 0x918 and high target 0x91C. Each field reads back what was written, with unused bits 0.
- R4: A region hits only when all of the following hold: it is enabled, `req_addr[63:32]` equals its high base, and `req_addr[31:0]` is at least its low base and at most its limit. Both bounds are inclusive.
- R5: On a hit, `out_addr` = target + (`req_addr` − base), computed modulo 2^64, and `out_type` is the region's type code.
- R6: When several regions hit, the one with the lowest index wins.
- R7: When no region hits, `out_miss` is 1, `out_addr` equals `req_addr` and `out_type` is 0.
- R8: Writes made while bit 31 of the window select is 1 go to separate inbound storage. That storage can be read back but never affects a lookup or any outbound field.
- R9: `out_valid` is asserted in the cycle after a cycle in which `req_valid` is high, and is 0 otherwise.
- R10: A read of 0x908 in the cycle after a write to it returns the enable bit just written. Software can use this read as a completion fence.
- R11: Offsets other than 0x900–0x91C read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Combinational readback of `reg_addr` |
| req_valid | input | 1 | Lookup request valid |
| req_addr | input | 64 | Address to translate |
| out_valid | output | 1 | Lookup result valid |
| out_addr | output | 64 | Translated or passed-through address |
| out_type | output | 3 | Type code of the winning region |
| out_miss | output | 1 | No enabled region matched |

## Verification
Four regions are set up with different types and targets, and lookups are driven through them:
- Addresses at the exact low base and exact limit separate inclusive bounds from exclusive ones.
- Addresses one below a base or one past a limit catch off-by-one errors in the compare.
- An address whose low word lies inside a window but whose high word differs shows that the high base is actually compared.
- Addresses in the overlap of regions 0 and 1 tell lowest-index priority apart from highest-index priority.
- A target near the top of the 64-bit space checks that the result wraps.
- A programmed but disabled region, an inbound region that covers a probed address, and writes to unused offsets each separate a real gate from a missing one. In each case the bench looks at the lookup result or the readback.

// File: rtl/obaddr_xlate.sv
module obaddr_xlate #(
  parameter int N = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [11:0] reg_addr,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  input  logic        req_valid,
  input  logic [63:0] req_addr,
  output logic        out_valid,
  output logic [63:0] out_addr,
  output logic [2:0]  out_type,
  output logic        out_miss
);
  localparam int IDX_W  = (N > 1) ? $clog2(N) : 1;
  localparam int SLOTS  = 2 * N;
  localparam int SLOT_W = $clog2(SLOTS);
  localparam logic [11:0] A_SEL = 12'h900, A_TYP = 12'h904, A_EN  = 12'h908,
                          A_BLO = 12'h90C, A_BHI = 12'h910, A_LIM = 12'h914,
                          A_TLO = 12'h918, A_THI = 12'h91C;

  logic             sel_in;
  logic [IDX_W-1:0] sel_idx;
  logic [2:0]  typ [SLOTS];
  logic        en  [SLOTS];
  logic [31:0] blo [SLOTS], bhi [SLOTS], lim [SLOTS], tlo [SLOTS], thi [SLOTS];

  wire              sel_ok = 32'(sel_idx) < N;
  wire [SLOT_W-1:0] slot   = (sel_in ? SLOT_W'(N) : '0) + SLOT_W'(sel_idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_in  <= 1'b0;
      sel_idx <= '0;
      for (int i = 0; i < SLOTS; i++) begin
        typ[i] <= '0; en[i] <= 1'b0; blo[i] <= '0; bhi[i] <= '0;
        lim[i] <= '0; tlo[i] <= '0; thi[i] <= '0;
      end
    end else if (wr_en) begin
      if (reg_addr == A_SEL) begin
        sel_in  <= wr_data[31];
        sel_idx <= wr_data[IDX_W-1:0];
      end else if (sel_ok) begin
        case (reg_addr)
          A_TYP: typ[slot] <= wr_data[2:0];
          A_EN:  en[slot]  <= wr_data[31];
          A_BLO: blo[slot] <= wr_data;
          A_BHI: bhi[slot] <= wr_data;
          A_LIM: lim[slot] <= wr_data;
          A_TLO: tlo[slot] <= wr_data;
          A_THI: thi[slot] <= wr_data;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (reg_addr == A_SEL) begin
      rd_data[31]        = sel_in;
      rd_data[IDX_W-1:0] = sel_idx;
    end else if (sel_ok) begin
      case (reg_addr)
        A_TYP: rd_data[2:0] = typ[slot];
        A_EN:  rd_data[31]  = en[slot];
        A_BLO: rd_data = blo[slot];
        A_BHI: rd_data = bhi[slot];
        A_LIM: rd_data = lim[slot];
        A_TLO: rd_data = tlo[slot];
        A_THI: rd_data = thi[slot];
        default: ;
      endcase
    end
  end

  logic              hit;
  logic [SLOT_W-1:0] win;
  always_comb begin
    hit = 1'b0;
    win = '0;
    for (int i = N - 1; i >= 0; i--)
      if (en[i] && req_addr[63:32] == bhi[i] &&
          req_addr[31:0] >= blo[i] && req_addr[31:0] <= lim[i]) begin
        hit = 1'b1;
        win = SLOT_W'(i);
      end
  end

  wire [63:0] xlat = {thi[win], tlo[win]} + (req_addr - {bhi[win], blo[win]});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_type  <= '0;
      out_miss  <= 1'b0;
    end else begin
      out_valid <= req_valid;
      if (req_valid) begin
        out_addr <= hit ? xlat : req_addr;
        out_type <= hit ? typ[win] : 3'd0;
        out_miss <= !hit;
      end
    end
  end
endmodule

// File: rtl/obaddr_xlate_chk.sv
module obaddr_xlate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [11:0] reg_addr,
  input logic [31:0] wr_data,
  input logic [31:0] rd_data,
  input logic        req_valid,
  input logic [63:0] req_addr,
  input logic        out_valid,
  input logic [63:0] out_addr,
  input logic [2:0]  out_type,
  input logic        out_miss
);
  p_valid_lat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid);
  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !out_valid);
  p_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (out_miss -> out_addr == $past(req_addr)));
  p_misstype_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_miss) |-> out_type == 3'd0);
  p_fence_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_addr == 12'h908) ##1 (!wr_en && reg_addr == 12'h908)
      |-> rd_data == ($past(wr_data) & 32'h8000_0000));
  p_hole_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr < 12'h900 || reg_addr > 12'h91F) |-> rd_data == 32'd0);
endmodule

bind obaddr_xlate obaddr_xlate_chk u_chk (.*);

// File: tb/tb_obaddr_xlate.sv
module tb_obaddr_xlate;
  logic        clk = 0, rst_n = 0, wr_en = 0, req_valid = 0;
  logic [11:0] reg_addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic [63:0] req_addr = '0, out_addr;
  logic [2:0]  out_type;
  logic        out_valid, out_miss;
  int errors = 0, checks = 0, cyc = 0;

  obaddr_xlate dut (.*);

  always #10 clk = ~clk;

  localparam int NV = 10;
  localparam logic [63:0] VA [NV] = '{
    64'h1_1000_0000, 64'h1_1000_7FFF, 64'h1_1000_8000, 64'h1_1001_0000,
    64'h1_1001_FFFF, 64'h1_1002_0000, 64'h0_1000_0000, 64'h0_4000_0800,
    64'h0_3FFF_FFFF, 64'h0_5000_0010};
  localparam logic [63:0] VX [NV] = '{
    64'h0_0100_0000, 64'h0_0100_7FFF, 64'h0_0100_8000, 64'h2_0000_8000,
    64'h2_0001_7FFF, 64'h1_1002_0000, 64'h0_1000_0000, 64'h0_0000_0700,
    64'h0_3FFF_FFFF, 64'h0_5000_0010};
  localparam logic [2:0] VT [NV] = '{4, 4, 4, 0, 0, 0, 0, 2, 0, 0};
  localparam logic       VM [NV] = '{0, 0, 0, 0, 0, 1, 1, 0, 1, 1};

  task automatic chk(string r, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1; reg_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = rd_data;
  endtask

  task automatic look(logic [63:0] a);
    @(negedge clk); req_valid = 1; req_addr = a;
    @(negedge clk); req_valid = 0;
  endtask

  task automatic region(logic [31:0] sel, logic [31:0] bh, logic [31:0] bl,
                        logic [31:0] li, logic [31:0] th, logic [31:0] tl,
                        logic [2:0] ty, logic e);
    wr(12'h900, sel); wr(12'h904, {29'd0, ty}); wr(12'h90C, bl);
    wr(12'h910, bh); wr(12'h914, li); wr(12'h918, tl); wr(12'h91C, th);
    wr(12'h908, {e, 31'd0});
  endtask

  initial begin
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 20000) begin
        errors++; checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1 out_valid after reset", 64'(out_valid), 0);
    rd(12'h908, d); chk("R1 enable after reset", 64'(d), 0);
    rd(12'h90C, d); chk("R1 base after reset", 64'(d), 0);
    look(64'h0);
    chk("R1 miss after reset", 64'(out_miss), 1);
    chk("R9 valid one cycle later", 64'(out_valid), 1);
    @(negedge clk); chk("R9 valid drops", 64'(out_valid), 0);

    region(32'd0, 32'd1, 32'h1000_0000, 32'h1000_FFFF, 32'd0, 32'h0100_0000, 3'd4, 1);
    region(32'd1, 32'd1, 32'h1000_8000, 32'h1001_FFFF, 32'd2, 32'h0000_0000, 3'd0, 1);
    region(32'd2, 32'd0, 32'h5000_0000, 32'h5000_FFFF, 32'd0, 32'h0, 3'd5, 0);
    region(32'd3, 32'd0, 32'h4000_0000, 32'h4000_0FFF, 32'hFFFF_FFFF, 32'hFFFF_FF00, 3'd2, 1);

    for (int i = 0; i < NV; i++) begin
      look(VA[i]);
      chk($sformatf("R4 R5 R6 R7 vec%0d addr", i), out_addr, VX[i]);
      chk($sformatf("R5 R7 vec%0d type", i), 64'(out_type), 64'(VT[i]));
      chk($sformatf("R4 R7 vec%0d miss", i), 64'(out_miss), 64'(VM[i]));
    end

    // R10 fence: enable region 2, read in the very next cycle
    wr(12'h900, 32'd2);
    @(negedge clk); wr_en = 1; reg_addr = 12'h908; wr_data = 32'h8000_0000;
    @(negedge clk); wr_en = 0; #1 chk("R10 fence readback", 64'(rd_data), 64'h8000_0000);
    rd(12'h904, d); chk("R3 type readback", 64'(d), 5);
    rd(12'h914, d); chk("R3 limit readback", 64'(d), 64'h5000_FFFF);
    look(64'h0_5000_0010);
    chk("R4 R5 enabled region2 addr", out_addr, 64'h10);
    chk("R5 enabled region2 type", 64'(out_type), 5);

    // R2 select readback, out-of-width bits dropped
    wr(12'h900, 32'h8000_00FF);
    rd(12'h900, d); chk("R2 select readback", 64'(d), 64'h8000_0003);

    // R8 inbound storage
    region(32'h8000_0003, 32'd0, 32'h6000_0000, 32'h6000_FFFF, 32'd0, 32'h0, 3'd4, 1);
    rd(12'h90C, d); chk("R8 inbound base readback", 64'(d), 64'h6000_0000);
    look(64'h0_6000_0000);
    chk("R8 inbound never hits", 64'(out_miss), 1);
    wr(12'h900, 32'd3);
    rd(12'h90C, d); chk("R8 outbound base untouched", 64'(d), 64'h4000_0000);
    rd(12'h904, d); chk("R8 outbound type untouched", 64'(d), 2);

    // R11 unused offsets
    wr(12'h920, 32'hFFFF_FFFF);
    rd(12'h920, d); chk("R11 hole reads zero", 64'(d), 0);
    rd(12'h90C, d); chk("R11 hole write no effect", 64'(d), 64'h4000_0000);
    look(64'h0_4000_0FFF);
    chk("R4 R11 limit edge after hole write", out_addr, 64'h0_0000_0EFF);

    // R1 reset again clears regions
    @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
    look(64'h1_1000_0000);
    chk("R1 regions cleared by reset", 64'(out_miss), 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule